// File: doc/BRIEF.md
# Selectable Test-Pattern Pixel Generator

This block turns a stream of pixel coordinates into a 4-bit red, green and blue colour value for each pixel. A separate sync timing generator supplies the horizontal and vertical positions and an active-video flag. A 4-bit mode switch picks the picture. There are three geometric patterns built around the screen centre: a horizontal band, a vertical band and a small square. The fourth picture is a 160x120 grayscale image that is scaled up to fill a 640x480 area. Only red carries the picture. Green and blue stay at zero, which saves the storage that a three-plane image would need.

The block is a two-stage pipeline. The first stage registers the band-hit flags, the image sample, the switch value and the blanking flag. The second stage picks the colour and registers it. Every mode therefore shows its colour exactly two clocks after the position that produced it, and a switch change takes effect without stopping the stream. The image content is a deterministic function of the column and row. A bench can predict every sample without reading any storage.

Top module: `tp_pattern_gen`

## Requirements
- R1: The green and blue outputs are 0 at all times.
- R2: When the active-video flag was low for a pixel, all three colour outputs for that pixel are 0, whatever the switch value.
- R3: When switch bit 0 is set, red is 0xF if the vertical position lies within 230..250 inclusive (centre 240 ± 10), and 0 otherwise.
- R4: When bit 1 is the lowest set switch bit, red is 0xF if the horizontal position lies within 310..330 inclusive (centre 320 ± 10), and 0 otherwise.
- R5: When bit 2 is the lowest set switch bit, red is 0xF only if both the R3 and R4 range conditions hold, and 0 otherwise.
- R6: When bit 3 is the only set switch bit, red equals the image sample at column x/4 and row y/4. The sample is bits [7:4] of (7·column + 13·row) mod 256. Red is 0 when the column is 160 or more, or the row is 120 or more.
- R7: The lowest-numbered set switch bit decides the mode. With all four bits clear, red is 0.
- R8: Each output shows the result for the position, flag and switch value presented exactly two clocks earlier. This holds even when the inputs change on every clock.
- R9: While reset is asserted, and on the first edges after it, all colour outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_x | input | 12 | Horizontal pixel position |
| pix_y | input | 12 | Vertical pixel position |
| video_on | input | 1 | High during the visible area |
| mode_sw | input | 4 | Mode switches; the lowest set bit wins |
| red | output | 4 | Red colour level |
| green | output | 4 | Green colour level (always 0) |
| blue | output | 4 | Blue colour level (always 0) |

## Verification
The bench builds the block with its default parameters: a 640x480 area, centre (320, 240), a band half-width of 10 and a scale shift of 2. The image is computed from its address rather than stored, so these full-size defaults stay cheap. Because of that, the bench can walk every switch value across both band edges, and it can sample the whole screen in image mode, including the column and row limits. The inputs change on every clock, so any error in pipeline alignment or in mode priority shows up directly as a mismatch.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int unsigned PIX_W = 12;
  localparam int unsigned COL_W = 4;

  typedef enum logic [2:0] {
    MODE_BLACK  = 3'd0,
    MODE_HBAND  = 3'd1,
    MODE_VBAND  = 3'd2,
    MODE_SQUARE = 3'd3,
    MODE_IMAGE  = 3'd4
  } tp_mode_e;

  // Inclusive window test: centre-half <= pos <= centre+half, without wrap.
  function automatic logic band_hit(input logic [PIX_W-1:0] pos,
                                    input logic [PIX_W-1:0] centre,
                                    input logic [PIX_W-1:0] half);
    logic [PIX_W:0] p, c, h;
    p = {1'b0, pos};
    c = {1'b0, centre};
    h = {1'b0, half};
    return ((p + h) >= c) && (p <= (c + h));
  endfunction

  // Grayscale image content: the upper nibble of an 8-bit synthetic pixel.
  function automatic logic [COL_W-1:0] img_sample(input logic [PIX_W-1:0] col,
                                                  input logic [PIX_W-1:0] row);
    logic [7:0] byte_val;
    byte_val = 8'((32'(col) * 7) + (32'(row) * 13));
    return byte_val[7:4];
  endfunction

  // The lowest-numbered set switch bit has priority.
  function automatic tp_mode_e pick_mode(input logic [3:0] sw);
    if (sw[0])      return MODE_HBAND;
    else if (sw[1]) return MODE_VBAND;
    else if (sw[2]) return MODE_SQUARE;
    else if (sw[3]) return MODE_IMAGE;
    else            return MODE_BLACK;
  endfunction
endpackage

// File: rtl/tp_shape_gen.sv
module tp_shape_gen
  import tp_pkg::*;
#(
  parameter int unsigned H_CENTRE = 320,
  parameter int unsigned V_CENTRE = 240,
  parameter int unsigned HALF_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_x,
  input  logic [PIX_W-1:0] pix_y,
  input  logic             video_on,
  input  logic [3:0]       mode_sw,
  output logic             s1_valid,
  output logic             s1_video,
  output tp_mode_e         s1_mode,
  output logic             s1_hit_h,
  output logic             s1_hit_v
);
  localparam logic [PIX_W-1:0] HC = PIX_W'(H_CENTRE);
  localparam logic [PIX_W-1:0] VC = PIX_W'(V_CENTRE);
  localparam logic [PIX_W-1:0] HW = PIX_W'(HALF_W);

  logic row_in_band;
  logic col_in_band;

  assign row_in_band = band_hit(pix_y, VC, HW);
  assign col_in_band = band_hit(pix_x, HC, HW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_video <= 1'b0;
      s1_mode  <= MODE_BLACK;
      s1_hit_h <= 1'b0;
      s1_hit_v <= 1'b0;
    end else begin
      s1_valid <= 1'b1;
      s1_video <= video_on;
      s1_mode  <= pick_mode(mode_sw);
      s1_hit_h <= row_in_band;
      s1_hit_v <= col_in_band;
    end
  end

  // The stage-1 mode register follows the switch priority one edge later.
  assert_mode_prio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sw[0] |=> (s1_mode == MODE_HBAND));
endmodule

// File: rtl/tp_image_rom.sv
module tp_image_rom
  import tp_pkg::*;
#(
  parameter int unsigned IMG_W       = 160,
  parameter int unsigned IMG_H       = 120,
  parameter int unsigned SCALE_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_x,
  input  logic [PIX_W-1:0] pix_y,
  output logic [COL_W-1:0] rom_q
);
  localparam logic [PIX_W-1:0] COL_LIM = PIX_W'(IMG_W);
  localparam logic [PIX_W-1:0] ROW_LIM = PIX_W'(IMG_H);

  logic [PIX_W-1:0] col_addr;
  logic [PIX_W-1:0] row_addr;
  logic             addr_ok;

  assign col_addr = pix_x >> SCALE_SHIFT;
  assign row_addr = pix_y >> SCALE_SHIFT;
  assign addr_ok  = (col_addr < COL_LIM) && (row_addr < ROW_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rom_q <= '0;
    else        rom_q <= addr_ok ? img_sample(col_addr, row_addr) : '0;
  end

  assert_rom_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_x >= PIX_W'(IMG_W << SCALE_SHIFT)) |=> (rom_q == '0));
endmodule

// File: rtl/tp_color_out.sv
module tp_color_out
  import tp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic             s1_video,
  input  tp_mode_e         s1_mode,
  input  logic             s1_hit_h,
  input  logic             s1_hit_v,
  input  logic [COL_W-1:0] rom_q,
  output logic [COL_W-1:0] red,
  output logic [COL_W-1:0] green,
  output logic [COL_W-1:0] blue
);
  localparam logic [COL_W-1:0] FULL = '1;

  logic [COL_W-1:0] red_next;

  always_comb begin
    red_next = '0;
    if (s1_video) begin
      case (s1_mode)
        MODE_HBAND:  red_next = s1_hit_h ? FULL : '0;
        MODE_VBAND:  red_next = s1_hit_v ? FULL : '0;
        MODE_SQUARE: red_next = (s1_hit_h && s1_hit_v) ? FULL : '0;
        MODE_IMAGE:  red_next = rom_q;
        default:     red_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) red <= '0;
    else        red <= red_next;
  end

  assign green = '0;
  assign blue  = '0;

  assert_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_video) |=> (red == '0));
  assert_no_mode_black_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_mode == MODE_BLACK) |=> (red == '0));
  assert_hband_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_video && s1_mode == MODE_HBAND && s1_hit_h) |=> (red == FULL));
  assert_image_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_video && s1_mode == MODE_IMAGE) |=> (red == $past(rom_q)));
endmodule

// File: rtl/tp_pattern_gen.sv
module tp_pattern_gen
  import tp_pkg::*;
#(
  parameter int unsigned H_CENTRE    = 320,
  parameter int unsigned V_CENTRE    = 240,
  parameter int unsigned HALF_W      = 10,
  parameter int unsigned IMG_W       = 160,
  parameter int unsigned IMG_H       = 120,
  parameter int unsigned SCALE_SHIFT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] pix_x,
  input  logic [11:0] pix_y,
  input  logic        video_on,
  input  logic [3:0]  mode_sw,
  output logic [3:0]  red,
  output logic [3:0]  green,
  output logic [3:0]  blue
);
  logic             s1_valid;
  logic             s1_video;
  tp_mode_e         s1_mode;
  logic             s1_hit_h;
  logic             s1_hit_v;
  logic [COL_W-1:0] rom_q;
  logic [1:0]       run_cnt;

  tp_shape_gen #(.H_CENTRE(H_CENTRE), .V_CENTRE(V_CENTRE), .HALF_W(HALF_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .video_on(video_on), .mode_sw(mode_sw),
    .s1_valid(s1_valid), .s1_video(s1_video), .s1_mode(s1_mode),
    .s1_hit_h(s1_hit_h), .s1_hit_v(s1_hit_v)
  );

  tp_image_rom #(.IMG_W(IMG_W), .IMG_H(IMG_H), .SCALE_SHIFT(SCALE_SHIFT)) u_rom (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y), .rom_q(rom_q)
  );

  tp_color_out u_out (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_video(s1_video),
    .s1_mode(s1_mode), .s1_hit_h(s1_hit_h), .s1_hit_v(s1_hit_v),
    .rom_q(rom_q), .red(red), .green(green), .blue(blue)
  );

  // Cycles since reset, saturating, used to gate two-deep history checks.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_cnt <= '0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  assert_gb_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (green == '0) && (blue == '0));
  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt >= 2'd2 && !$past(video_on, 2)) |-> (red == '0));
  assert_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == 2'd0) |-> (red == '0));
endmodule

// File: tb/sim_tp_pattern_gen.sv
module sim_tp_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pix_x = '0;
  logic [11:0] pix_y = '0;
  logic        video_on = 1'b0;
  logic [3:0]  mode_sw = '0;
  logic [3:0]  red, green, blue;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // History of driven inputs: index 0 = latest, 1 = one clock earlier.
  int  hx [2];
  int  hy [2];
  bit  hv [2];
  int  hs [2];
  int  filled = 0;

  tp_pattern_gen u0 (.clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .video_on(video_on), .mode_sw(mode_sw), .red(red), .green(green), .blue(blue));

  always #10 clk = ~clk;

  function automatic int expect_red(int x, int y, bit v, int sw);
    bit hh, vh;
    int col, row;
    if (!v) return 0;                                   // R2
    hh = (y >= 230 && y <= 250);
    vh = (x >= 310 && x <= 330);
    if (sw % 2 == 1)       return hh ? 15 : 0;           // R3
    if ((sw / 2) % 2 == 1) return vh ? 15 : 0;           // R4
    if ((sw / 4) % 2 == 1) return (hh && vh) ? 15 : 0;   // R5
    if ((sw / 8) % 2 == 1) begin                         // R6
      col = x / 4; row = y / 4;
      if (col >= 160 || row >= 120) return 0;
      return ((col * 7 + row * 13) % 256) / 16;
    end
    return 0;                                            // R7
  endfunction

  function automatic string req_of(int sw, bit v);
    if (!v) return "R2";
    if (sw % 2 == 1) return "R3";
    if ((sw / 2) % 2 == 1) return "R4";
    if ((sw / 4) % 2 == 1) return "R5";
    if ((sw / 8) % 2 == 1) return "R6";
    return "R7";
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // At a falling edge: check the output of the inputs from two clocks ago (R8),
  // then drive a new pixel.
  task automatic step(int x, int y, bit v, int sw);
    @(negedge clk);
    if (filled >= 2) begin
      check({req_of(hs[1], hv[1]), "/R8"}, int'(red), expect_red(hx[1], hy[1], hv[1], hs[1]));
      check("R1", int'({green, blue}), 0);
    end
    hx[1] = hx[0]; hy[1] = hy[0]; hv[1] = hv[0]; hs[1] = hs[0];
    hx[0] = x; hy[0] = y; hv[0] = v; hs[0] = sw;
    if (filled < 2) filled++;
    pix_x = 12'(x); pix_y = 12'(y); video_on = v; mode_sw = 4'(sw);
  endtask

  initial begin
    #5000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", int'({red, green, blue}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", int'(red), 0);
    // Sweep every switch value across band edges, toggling blanking.
    for (int sw = 0; sw < 16; sw++)
      for (int x = 300; x <= 340; x += 2)
        for (int y = 226; y <= 254; y += 4)
          step(x, y, ((x + y) % 7) != 0, sw);
    // Exact band edges in each shape mode.
    for (int sw = 1; sw <= 4; sw = sw * 2)
      for (int d = 228; d <= 252; d++) begin
        step(d + 80, d, 1'b1, sw);
        step(320, d, 1'b1, sw);
        step(d + 80, 240, 1'b1, sw);
      end
    // Whole-screen image sweep, including beyond-image coordinates.
    for (int y = 0; y < 490; y += 5)
      for (int x = 0; x < 660; x += 7)
        step(x, y, 1'b1, 8);
    // Switch value changing every clock.
    for (int i = 0; i < 400; i++)
      step((i * 37) % 640, (i * 11) % 480, 1'b1, i % 16);
    step(0, 0, 1'b0, 0);
    step(0, 0, 1'b0, 0);
    step(0, 0, 1'b0, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule